// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block is a memory-mapped real-time clock peripheral. A one-second tick input advances a 32-bit elapsed-seconds up-counter. On the same tick it retreats a companion down-counter, which software loads with the bitwise complement of the up-count. Two comparators watch the up-counter against programmable alarm values. A hit latches a status bit, which drives an interrupt, and can also raise a power-on request output.

Software reaches everything through a simple synchronous register port: a byte address, a write enable, write data and registered read data. A key register survives the block's own software reset. Boot code writes a chosen marker value there and checks it on later boots to learn whether the clock was already set up. Control bits can stop the counters so that both can be reloaded consistently. Another bit holds the whole time base in its cleared state.

Top module: `secClockAlarm`

## Requirements
- R1: After hardware reset, every register reads zero except the down-counter, which reads 0xFFFFFFFF. `irqOut` and `powerOnOut` are low.
- R2: On each cycle with `tickIn` high, the up-counter (offset 0x00) increments by one and the down-counter (0x04) decrements by one. Ticks have no effect while control bit 6 (counter stop) is set.
- R3: A write to offset 0x00 or 0x04 loads that counter at any time. If the write coincides with a tick, the written value wins for that counter, and the other counter still steps.
- R4: Alarm channel n (value at 0x08 for n=0, 0x0C for n=1) sets status bit n on the tick that makes the up-count equal the alarm value, provided control bit n is set. An alarm value of 0xFFFFFFFF never sets status.
- R5: Status bits (offset 0x14: bit 0 alarm 0, bit 1 alarm 1, bit 2 power-on event) stay latched until cleared. Writing 1 to a bit clears it and writing 0 leaves it. A new event in the same cycle as a clear leaves the bit set.
- R6: `irqOut` is high exactly when status bit 0 or bit 1 is set. The power-on status bit does not drive it.
- R7: `powerOnOut` is high when control bit 7 (force) is set, or when control bit 2 (or 3) is set and the up-count currently equals alarm 0 (or 1). A tick that reaches an alarm whose power-on enable is set sets status bit 2.
- R8: While control bit 4 (software reset) is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF. Ticks and counter writes are ignored and all status bits read 0. The key register keeps its value.
- R9: The key register at offset 0x18 reads back the last 32-bit value written, for example 0xB5C13F27.
- R10: Read data appears on the clock edge after the address is presented. Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 return 0. The control register reads back bits 0–4, 6 and 7 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rstN | input | 1 | Active-low hardware reset |
| busAddr | input | 5 | Byte offset of the register accessed |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| tickIn | input | 1 | One-cycle pulse per second |
| irqOut | output | 1 | Alarm interrupt request |
| powerOnOut | output | 1 | Power-on request output |

## Verification
Several properties are checked on every cycle:
- the up-counter holds when no tick or load is applied;
- software reset clears the counters and status one edge later;
- a latched alarm status bit persists until cleared;
- alarm 0 only ever rises onto the programmed value;
- unmapped reads return zero;
- the key register changes only on its own write.

The bench scenarios are needed for the rest:
- that a load beats a concurrent tick while the other counter still steps;
- that an all-ones alarm never fires;
- that an event wins over a same-cycle clear;
- that the power-on output follows the equality window and the force bit without touching the interrupt.

// File: rtl/secClockPkg.sv
package secClockPkg;

  // Register byte offsets; software-visible, so fixed.
  localparam int unsigned OFF_UP   = 'h00;
  localparam int unsigned OFF_DOWN = 'h04;
  localparam int unsigned OFF_M0   = 'h08;
  localparam int unsigned OFF_M1   = 'h0C;
  localparam int unsigned OFF_CTRL = 'h10;
  localparam int unsigned OFF_ST   = 'h14;
  localparam int unsigned OFF_KEY  = 'h18;

  localparam int unsigned NUM_ALARM = 2;
  localparam int unsigned ST_W      = NUM_ALARM + 1;

  // Control bit positions.
  localparam int unsigned CB_EN0    = 0;
  localparam int unsigned CB_EN1    = 1;
  localparam int unsigned CB_ON0    = 2;
  localparam int unsigned CB_ON1    = 3;
  localparam int unsigned CB_SWRST  = 4;
  localparam int unsigned CB_STOP   = 6;
  localparam int unsigned CB_FORCE  = 7;
  localparam logic [7:0]  CTRL_MASK = 8'hDF;

  // Strobes from the control side into the datapath.
  typedef struct packed {
    logic            wrUp;
    logic            wrDown;
    logic [ST_W-1:0] clrSt;
  } strobeT;

  // Static configuration decoded from the control register.
  typedef struct packed {
    logic                 swRst;
    logic                 cntStop;
    logic                 forceOn;
    logic [NUM_ALARM-1:0] alarmEn;
    logic [NUM_ALARM-1:0] onEn;
  } cfgT;

endpackage

// File: rtl/secClockCtrl.sv
module secClockCtrl
  import secClockPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWe,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [DATA_W-1:0]              upVal,
  input  logic [DATA_W-1:0]              downVal,
  input  logic [ST_W-1:0]                stVal,
  output logic [DATA_W-1:0]              busRdata,
  output strobeT                         strb,
  output cfgT                            cfg,
  output logic [NUM_ALARM-1:0][DATA_W-1:0] alarmVal
);

  localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(OFF_UP);
  localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(OFF_DOWN);
  localparam logic [ADDR_W-1:0] A_M0   = ADDR_W'(OFF_M0);
  localparam logic [ADDR_W-1:0] A_M1   = ADDR_W'(OFF_M1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(OFF_ST);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);

  logic [7:0]        ctrlReg;
  logic [DATA_W-1:0] keyReg;
  logic [DATA_W-1:0] rdNext;
  logic              isMapped;

  // Alarm value registers, one per channel at consecutive words.
  for (genvar gi = 0; gi < NUM_ALARM; gi++) begin : g_alarm
    localparam logic [ADDR_W-1:0] A_MN = ADDR_W'(OFF_M0 + 4 * gi);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        alarmVal[gi] <= '0;
      else if (busWe && busAddr == A_MN) alarmVal[gi] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      keyReg  <= '0;
    end else if (busWe) begin
      if (busAddr == A_CTRL) ctrlReg <= busWdata[7:0] & CTRL_MASK;
      if (busAddr == A_KEY)  keyReg  <= busWdata;
    end
  end

  always_comb begin
    strb.wrUp   = busWe && (busAddr == A_UP);
    strb.wrDown = busWe && (busAddr == A_DOWN);
    strb.clrSt  = (busWe && (busAddr == A_ST)) ? busWdata[ST_W-1:0] : '0;
  end

  assign cfg.swRst   = ctrlReg[CB_SWRST];
  assign cfg.cntStop = ctrlReg[CB_STOP];
  assign cfg.forceOn = ctrlReg[CB_FORCE];
  assign cfg.alarmEn = {ctrlReg[CB_EN1], ctrlReg[CB_EN0]};
  assign cfg.onEn    = {ctrlReg[CB_ON1], ctrlReg[CB_ON0]};

  always_comb begin
    rdNext   = '0;
    isMapped = 1'b1;
    case (busAddr)
      A_UP:    rdNext = upVal;
      A_DOWN:  rdNext = downVal;
      A_M0:    rdNext = alarmVal[0];
      A_M1:    rdNext = alarmVal[1];
      A_CTRL:  rdNext = DATA_W'(ctrlReg);
      A_ST:    rdNext = DATA_W'(stVal);
      A_KEY:   rdNext = keyReg;
      default: isMapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  // R10: unmapped offsets read zero one edge later.
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |=> busRdata == '0);

  // R9: the key only changes on its own write.
  a_r9_key_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == A_KEY) |=> $stable(keyReg));

endmodule

// File: rtl/secClockPath.sv
module secClockPath
  import secClockPkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tickIn,
  input  strobeT                           strb,
  input  cfgT                              cfg,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_ALARM-1:0][DATA_W-1:0] alarmVal,
  output logic [DATA_W-1:0]                upCnt,
  output logic [DATA_W-1:0]                downCnt,
  output logic [ST_W-1:0]                  status,
  output logic                             powerOn
);

  localparam logic [DATA_W-1:0] ALL1 = '1;

  logic                 tickEff;
  logic [DATA_W-1:0]    upNext;
  logic [NUM_ALARM-1:0] hit;
  logic [NUM_ALARM-1:0] eqNow;
  logic [ST_W-1:0]      setSt;

  assign tickEff = tickIn && !cfg.cntStop && !cfg.swRst;
  assign upNext  = upCnt + 1'b1;

  // One comparator pair per alarm channel; all-ones means never.
  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_cmp
    logic armed;
    assign armed    = alarmVal[g] != ALL1;
    assign hit[g]   = tickEff && !strb.wrUp && armed && (upNext == alarmVal[g]);
    assign eqNow[g] = armed && (upCnt == alarmVal[g]);
  end

  assign setSt   = {|(hit & cfg.onEn), hit & cfg.alarmEn};
  assign powerOn = cfg.forceOn || |(eqNow & cfg.onEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt   <= '0;
      downCnt <= ALL1;
    end else if (cfg.swRst) begin
      upCnt   <= '0;
      downCnt <= ALL1;
    end else begin
      if (strb.wrUp)        upCnt <= wrData;
      else if (tickEff)     upCnt <= upNext;
      if (strb.wrDown)      downCnt <= wrData;
      else if (tickEff)     downCnt <= downCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          status <= '0;
    else if (cfg.swRst) status <= '0;
    else                status <= (status & ~strb.clrSt) | setSt;
  end

  // R2: no tick and no load leaves the up-counter unchanged.
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.swRst && !tickEff && !strb.wrUp) |=> $stable(upCnt));

  // R8: software reset forces the cleared time base on the next edge.
  a_r8_sw_reset: assert property (@(posedge clk) disable iff (!rstN)
    cfg.swRst |=> (upCnt == '0 && downCnt == ALL1 && status == '0));

  // R5: an alarm-0 status bit stays latched unless cleared.
  a_r5_latched: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !strb.clrSt[0] && !cfg.swRst) |=> status[0]);

  // R4: alarm 0 only rises onto its programmed, non-all-ones value.
  a_r4_alarm_value: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> (upCnt == $past(alarmVal[0]) && $past(alarmVal[0]) != ALL1));

endmodule

// File: rtl/secClockAlarm.sv
module secClockAlarm
  import secClockPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickIn,
  output logic              irqOut,
  output logic              powerOnOut
);

  strobeT                           strb;
  cfgT                              cfg;
  logic [NUM_ALARM-1:0][DATA_W-1:0] alarmVal;
  logic [DATA_W-1:0]                upCnt;
  logic [DATA_W-1:0]                downCnt;
  logic [ST_W-1:0]                  status;

  secClockCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .upVal    (upCnt),
    .downVal  (downCnt),
    .stVal    (status),
    .busRdata (busRdata),
    .strb     (strb),
    .cfg      (cfg),
    .alarmVal (alarmVal)
  );

  secClockPath #(.DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .strb     (strb),
    .cfg      (cfg),
    .wrData   (busWdata),
    .alarmVal (alarmVal),
    .upCnt    (upCnt),
    .downCnt  (downCnt),
    .status   (status),
    .powerOn  (powerOnOut)
  );

  assign irqOut = |status[NUM_ALARM-1:0];

endmodule

// File: tb/test_secClockAlarm.sv
module test_secClockAlarm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIn = 1'b0;
  logic        irqOut;
  logic        powerOnOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  secClockAlarm i_secClockAlarm (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickIn(tickIn),
    .irqOut(irqOut), .powerOnOut(powerOnOut)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vecT;

  localparam int NV = 14;
  localparam vecT VEC [NV] = '{
    '{1'b1, 5'h18, 32'hB5C13F27, 32'h0},         // R9 key write
    '{1'b0, 5'h18, 32'h0,        32'hB5C13F27},  // R9 key read
    '{1'b1, 5'h08, 32'h12345678, 32'h0},
    '{1'b0, 5'h08, 32'h0,        32'h12345678},
    '{1'b1, 5'h0C, 32'h00000010, 32'h0},
    '{1'b0, 5'h0C, 32'h0,        32'h00000010},
    '{1'b1, 5'h10, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 5'h10, 32'h0,        32'h000000DF},  // R10 control mask
    '{1'b1, 5'h10, 32'h0,        32'h0},
    '{1'b0, 5'h1C, 32'h0,        32'h0},         // R10 unmapped
    '{1'b1, 5'h00, 32'h00000100, 32'h0},         // R3 load up
    '{1'b0, 5'h00, 32'h0,        32'h00000100},
    '{1'b1, 5'h04, 32'h00000ABC, 32'h0},         // R3 load down
    '{1'b0, 5'h04, 32'h0,        32'h00000ABC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(posedge clk);
    #1 d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    chk("R1 powerOn", {31'b0, powerOnOut}, 32'h0);
    rdChk("R1 up", 5'h00, 32'h0);
    rdChk("R1 down", 5'h04, 32'hFFFFFFFF);
    rdChk("R1 ctrl", 5'h10, 32'h0);
    rdChk("R1 status", 5'h14, 32'h0);
    rdChk("R1 key", 5'h18, 32'h0);

    // Register table walk (R3, R9, R10)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else           rdChk("R3/R9/R10 table", VEC[i].addr, VEC[i].exp);
    end

    // R10 one-edge read latency
    rdChk("R10 key", 5'h18, 32'hB5C13F27);
    @(negedge clk); busAddr = 5'h0C;
    #1 chk("R10 latency old", busRdata, 32'hB5C13F27);
    @(posedge clk); #1 chk("R10 latency new", busRdata, 32'h10);
    rdChk("R10 unaligned", 5'h03, 32'h0);

    // R2 stepping and counter stop
    wr(5'h00, 32'd10); wr(5'h04, 32'hFFFFFFF5);
    ticks(3);
    rdChk("R2 up step", 5'h00, 32'd13);
    rdChk("R2 down step", 5'h04, 32'hFFFFFFF2);
    wr(5'h10, 32'h40);
    ticks(2);
    rdChk("R2 stop up", 5'h00, 32'd13);
    rdChk("R2 stop down", 5'h04, 32'hFFFFFFF2);
    wr(5'h10, 32'h0);

    // R3 load beats concurrent tick
    @(negedge clk);
    busAddr = 5'h00; busWdata = 32'd500; busWe = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickIn = 1'b0;
    rdChk("R3 load wins", 5'h00, 32'd500);
    rdChk("R3 other steps", 5'h04, 32'hFFFFFFF1);

    // R4 alarm 0 fires, R6 interrupt
    wr(5'h08, 32'd505); wr(5'h10, 32'h1);
    ticks(4);
    chk("R6 irq before", {31'b0, irqOut}, 32'h0);
    rdChk("R4 no early status", 5'h14, 32'h0);
    ticks(1);
    chk("R6 irq on alarm", {31'b0, irqOut}, 32'h1);
    rdChk("R4 alarm0 status", 5'h14, 32'h1);

    // R5 latch and write-1-clear
    ticks(1);
    rdChk("R5 latched", 5'h14, 32'h1);
    wr(5'h14, 32'h0);
    rdChk("R5 write0 keeps", 5'h14, 32'h1);
    wr(5'h14, 32'h2);
    rdChk("R5 other bit keeps", 5'h14, 32'h1);
    wr(5'h14, 32'h1);
    rdChk("R5 cleared", 5'h14, 32'h0);
    chk("R6 irq cleared", {31'b0, irqOut}, 32'h0);

    // R4 disabled channel does not fire
    wr(5'h0C, 32'd510);
    ticks(4);
    rdChk("R4 up at 510", 5'h00, 32'd510);
    rdChk("R4 disabled alarm1", 5'h14, 32'h0);

    // R4 all-ones alarm never fires
    wr(5'h00, 32'hFFFFFFFD); wr(5'h08, 32'hFFFFFFFF);
    ticks(2);
    rdChk("R4 up all ones", 5'h00, 32'hFFFFFFFF);
    rdChk("R4 never value", 5'h14, 32'h0);

    // R7 force bit, no interrupt
    wr(5'h10, 32'h80);
    chk("R7 force", {31'b0, powerOnOut}, 32'h1);
    chk("R6 force no irq", {31'b0, irqOut}, 32'h0);
    wr(5'h10, 32'h0);
    chk("R7 force off", {31'b0, powerOnOut}, 32'h0);

    // R7 power-on match on alarm 1
    wr(5'h10, 32'h08); wr(5'h0C, 32'd22); wr(5'h00, 32'd20);
    ticks(1);
    chk("R7 not yet", {31'b0, powerOnOut}, 32'h0);
    ticks(1);
    chk("R7 on at match", {31'b0, powerOnOut}, 32'h1);
    chk("R6 poweron no irq", {31'b0, irqOut}, 32'h0);
    rdChk("R7 poweron status", 5'h14, 32'h4);
    ticks(1);
    chk("R7 off after match", {31'b0, powerOnOut}, 32'h0);
    rdChk("R7 status latched", 5'h14, 32'h4);
    wr(5'h14, 32'h4);
    rdChk("R7 status cleared", 5'h14, 32'h0);

    // R5 event wins over same-cycle clear
    wr(5'h08, 32'd30); wr(5'h00, 32'd29); wr(5'h10, 32'h1);
    @(negedge clk);
    busAddr = 5'h14; busWdata = 32'h1; busWe = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickIn = 1'b0;
    rdChk("R5 set wins", 5'h14, 32'h1);

    // R8 software reset
    wr(5'h10, 32'h10);
    rdChk("R8 status cleared", 5'h14, 32'h0);
    rdChk("R8 up held", 5'h00, 32'h0);
    rdChk("R8 down held", 5'h04, 32'hFFFFFFFF);
    ticks(2);
    wr(5'h00, 32'd77);
    rdChk("R8 tick and load ignored", 5'h00, 32'h0);
    rdChk("R8 key kept", 5'h18, 32'hB5C13F27);
    chk("R8 irq low", {31'b0, irqOut}, 32'h0);
    wr(5'h10, 32'h0);
    ticks(1);
    rdChk("R8 resume up", 5'h00, 32'd1);
    rdChk("R8 resume down", 5'h04, 32'hFFFFFFFE);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule